// File: doc/BRIEF.md
# Eye-Opening Scan Controller

This block maps the open region of a serial receiver's data eye. It steps the receiver's sampler over a grid of voltage offsets and clock phases, giving each one a 5-bit code. At every grid point it counts how many of a fixed number of sampled bits were 1. It writes each count into an internal map and judges the point open or closed from that count.

While the sweep runs, the block keeps running statistics for each phase column. When the last point is finished it publishes three results: the open area of the eye, the best phase column, and the centre of the widest open offset span in that column. A host starts a scan and waits for the one-cycle completion pulse. It then reads the results, and it can fetch any stored count through the map read port.

Defaults are 5-bit phase and offset codes, which give a 32 x 32 grid, and a 2048-sample window.

Top module: `eye_scan_ctrl`

## Requirements
- R1: A scan visits every grid point exactly once. Phase is the outer loop and offset the inner loop, each running from code 0 up to its all-ones code. The first point of a scan is phase 0, offset 0.
- R2: After the scan starts, and after every code change, the block ignores sample strobes for S cycles. S is `settle_cycles` captured at start and clamped to the range 4 to 64.
- R3: After the settle time, the point closes on exactly WIN valid samples. Cycles with `smp_valid` low are not counted. The number of 1s among those WIN samples is the point's count.
- R4: The count for phase p and offset o is stored at map address {p, o}, with phase in the upper bits. `rd_data` returns the entry at `rd_addr` one cycle after the address is presented, and it holds that entry until the next scan rewrites it.
- R5: A point is open only when its count is 0 or WIN. Every other count marks it closed.
- R6: At the end of the scan, `area` equals the number of open points, from 0 to the grid size. It holds until the next scan completes.
- R7: `best_ph` is the phase column with the most open points. If columns tie, the lower phase code wins.
- R8: `best_ofs` is s + (L-1)/2, rounded down. Here s is the starting offset and L the length of the longest unbroken run of open offsets in the chosen column. If runs tie, the run at the lower offset wins.
- R9: If no point is open, `no_eye` is 1, `area` is 0, and both best codes are 0. Otherwise `no_eye` is 0.
- R10: `done` pulses high for one cycle when the results are published. `busy` is high from the cycle after `start` is accepted until `done`. A `start` that arrives while `busy` is high has no effect.
- R11: During reset, both codes, `busy`, `done`, `area`, `no_eye` and the best codes are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan when idle |
| settle_cycles | input | SET_W | Wait after each code change, clamped 4..64 |
| smp_bit | input | 1 | Bit captured by the sampler |
| smp_valid | input | 1 | smp_bit holds a fresh sample |
| rd_addr | input | PH_W+OFS_W | Map read address {phase, offset} |
| ofs_code | output | OFS_W | Voltage-offset code to the sampler |
| ph_code | output | PH_W | Phase code to the sampler |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | CNT_W | Stored count, one cycle after rd_addr |
| area | output | PH_W+OFS_W+1 | Number of open grid points |
| best_ph | output | PH_W | Chosen phase column |
| best_ofs | output | OFS_W | Centre of the widest open span in that column |
| no_eye | output | 1 | No open point found |

## Verification
The bench drives 1s with the strobe asserted throughout each settle window and after each window closes. A controller that counted early or late, or that did not clamp the settle setting, would store counts that are too high, and those counts show up in the map read-back. Counts of 1 and WIN-1 sit next to the open values to catch an open test that is off by one. One pattern has a tie between two columns, and the winning column holds two equal runs, while a longer run sits in the losing column. A design that broke ties upward or searched the whole grid for its run would report the wrong best point. A start pulse in the middle of a scan, a fully closed grid and a fully open grid check the restart guard, the no-eye flag and the maximum area.

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl #(
  parameter int PH_W    = 5,
  parameter int OFS_W   = 5,
  parameter int WIN     = 2048,
  parameter int SET_W   = 7,
  parameter int SET_MIN = 4,
  parameter int SET_MAX = 64,
  parameter int CNT_W   = $clog2(WIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SET_W-1:0]        settle_cycles,
  input  logic                    smp_bit,
  input  logic                    smp_valid,
  input  logic [PH_W+OFS_W-1:0]   rd_addr,
  output logic [OFS_W-1:0]        ofs_code,
  output logic [PH_W-1:0]         ph_code,
  output logic                    busy,
  output logic                    done,
  output logic [CNT_W-1:0]        rd_data,
  output logic [PH_W+OFS_W:0]     area,
  output logic [PH_W-1:0]         best_ph,
  output logic [OFS_W-1:0]        best_ofs,
  output logic                    no_eye
);
  localparam int AW  = PH_W + OFS_W;
  localparam int NPT = 1 << AW;

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_COUNT} st_t;
  st_t st;

  logic [CNT_W-1:0] mem [NPT];
  logic [SET_W-1:0] set_len, set_cnt, set_clamp;
  logic [CNT_W-1:0] ones, nsmp, pt_total;
  logic [OFS_W:0]   run_len, run_n, cb_len, cb_len_n, col_cnt, col_n, best_cnt;
  logic [OFS_W-1:0] run_st, run_st_n, cb_st, cb_st_n, mid, bo;
  logic [PH_W-1:0]  bp;
  logic [AW:0]      area_acc, area_n;
  logic             pt_last, pt_open, cb_take, col_end, scan_end, col_win;

  assign set_clamp = (settle_cycles < SET_W'(SET_MIN)) ? SET_W'(SET_MIN) :
                     (settle_cycles > SET_W'(SET_MAX)) ? SET_W'(SET_MAX) : settle_cycles;
  assign busy     = (st != S_IDLE);
  assign pt_last  = (st == S_COUNT) && smp_valid && (nsmp == CNT_W'(WIN - 1));
  assign pt_total = ones + CNT_W'(smp_bit);
  assign pt_open  = (pt_total == '0) || (pt_total == CNT_W'(WIN));
  assign run_n    = pt_open ? run_len + 1'b1 : '0;
  assign run_st_n = (run_len == '0) ? ofs_code : run_st;
  assign cb_take  = pt_open && (run_n > cb_len);
  assign cb_len_n = cb_take ? run_n : cb_len;
  assign cb_st_n  = cb_take ? run_st_n : cb_st;
  assign col_n    = col_cnt + {{OFS_W{1'b0}}, pt_open};
  assign area_n   = area_acc + {{AW{1'b0}}, pt_open};
  assign mid      = OFS_W'({1'b0, cb_st_n} + ((cb_len_n - 1'b1) >> 1));
  assign col_end  = (ofs_code == '1);
  assign scan_end = col_end && (ph_code == '1);
  assign col_win  = col_n > best_cnt;

  always_ff @(posedge clk) begin
    if (pt_last) mem[{ph_code, ofs_code}] <= pt_total;
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; set_len <= '0; set_cnt <= '0; ones <= '0; nsmp <= '0;
      ofs_code <= '0; ph_code <= '0; done <= 1'b0;
      run_len <= '0; run_st <= '0; cb_len <= '0; cb_st <= '0; col_cnt <= '0;
      best_cnt <= '0; bp <= '0; bo <= '0; area_acc <= '0;
      area <= '0; best_ph <= '0; best_ofs <= '0; no_eye <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_SETTLE; set_len <= set_clamp; set_cnt <= set_clamp;
          ofs_code <= '0; ph_code <= '0; ones <= '0; nsmp <= '0;
          run_len <= '0; cb_len <= '0; col_cnt <= '0;
          best_cnt <= '0; bp <= '0; bo <= '0; area_acc <= '0;
        end
        S_SETTLE: begin
          if (set_cnt == SET_W'(1)) st <= S_COUNT;
          else set_cnt <= set_cnt - 1'b1;
        end
        S_COUNT: if (smp_valid) begin
          if (!pt_last) begin
            ones <= pt_total;
            nsmp <= nsmp + 1'b1;
          end else begin
            ones <= '0; nsmp <= '0; area_acc <= area_n;
            ofs_code <= ofs_code + 1'b1;
            set_cnt <= set_len; st <= S_SETTLE;
            if (!col_end) begin
              run_len <= run_n; run_st <= run_st_n;
              cb_len <= cb_len_n; cb_st <= cb_st_n; col_cnt <= col_n;
            end else begin
              run_len <= '0; cb_len <= '0; col_cnt <= '0;
              ph_code <= ph_code + 1'b1;
              if (col_win) begin best_cnt <= col_n; bp <= ph_code; bo <= mid; end
            end
            if (scan_end) begin
              st <= S_IDLE; done <= 1'b1;
              area <= area_n; no_eye <= (area_n == '0);
              best_ph  <= col_win ? ph_code : bp;
              best_ofs <= col_win ? mid : bo;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_scan_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (ofs_code == '0 && ph_code == '0));
  p_ofs_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && ofs_code != $past(ofs_code)) |-> ofs_code == OFS_W'($past(ofs_code) + 1'b1));
  p_ph_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && ph_code != $past(ph_code)) |-> ($past(ofs_code) == '1 && ofs_code == '0));
  p_settle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SETTLE) |=> ($stable(ofs_code) && $stable(ph_code)));
  p_no_eye_area_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (no_eye == (area == '0)));
endmodule

// File: tb/eye_scan_ctrl_tb.sv
`timescale 1ns/1ps
module eye_scan_ctrl_tb_top;
  localparam int PHW = 3, OFW = 3, WIN = 16, AW = PHW + OFW, NPT = 1 << AW, CW = 5, SW = 7;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start, smp_bit, smp_valid, busy, done, no_eye;
  logic [SW-1:0] settle_cycles;
  logic [AW-1:0] rd_addr;
  logic [OFW-1:0] ofs_code, best_ofs;
  logic [PHW-1:0] ph_code, best_ph;
  logic [CW-1:0] rd_data;
  logic [AW:0] area;

  eye_scan_ctrl #(.PH_W(PHW), .OFS_W(OFW), .WIN(WIN), .SET_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .smp_bit(smp_bit), .smp_valid(smp_valid), .rd_addr(rd_addr),
    .ofs_code(ofs_code), .ph_code(ph_code), .busy(busy), .done(done),
    .rd_data(rd_data), .area(area), .best_ph(best_ph), .best_ofs(best_ofs), .no_eye(no_eye));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int exp_map[NPT];

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int pat(int sc, int ph, int of);
    case (sc)
      0: if (((ph == 3 || ph == 4) && of >= 2 && of <= 5) || ((ph == 2 || ph == 5) && (of == 3 || of == 4)))
           return ((ph + of) % 2 == 0) ? 0 : WIN;
         else return 1 + (ph * 7 + of * 3) % (WIN - 1);
      1: return 1 + (ph + of) % (WIN - 1);
      2: if (ph == 1 && (of <= 1 || of == 4 || of == 5)) return (of % 2 == 0) ? WIN : 0;
         else if (ph == 6 && ((of >= 2 && of <= 4) || of == 7)) return 0;
         else return WIN - 1 - (of % 3);
      default: return (of % 2 == 0) ? 0 : WIN;
    endcase
  endfunction

  task automatic scan(input int sc, input int set_in, input bit poke);
    int eff, e_area, bestc, bph, bof, pi, junk, sent, gap, cyc;
    logic pb; logic [OFW-1:0] po; logic [PHW-1:0] pp;
    eff = set_in < 4 ? 4 : (set_in > 64 ? 64 : set_in);
    e_area = 0; bestc = 0; bph = 0; bof = 0;
    for (int ph = 0; ph < (1 << PHW); ph++) begin
      int cc = 0, rl = 0, rs = 0, bl = 0, bs = 0;
      for (int of = 0; of < (1 << OFW); of++) begin
        int c = pat(sc, ph, of);
        exp_map[ph * (1 << OFW) + of] = c;
        if (c == 0 || c == WIN) begin
          if (rl == 0) rs = of;
          rl++; cc++;
          if (rl > bl) begin bl = rl; bs = rs; end
        end else rl = 0;
      end
      e_area += cc;
      if (cc > bestc) begin bestc = cc; bph = ph; bof = bs + (bl - 1) / 2; end
    end
    pi = -1; junk = 0; sent = 0; gap = 0; cyc = 0;
    settle_cycles = SW'(set_in);
    @(negedge clk);
    start = 1'b1; smp_valid = 1'b1; smp_bit = 1'b1;
    pb = busy; po = ofs_code; pp = ph_code;
    forever begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (cyc > 20000) begin chk(1'b0, "R10 scan never completed", cyc, 0); break; end
      if (done) begin
        chk(sent == WIN, "R3 samples in last point", sent, WIN);
        chk(pi == NPT - 1, "R1 points visited", pi + 1, NPT);
        chk(busy == 1'b0, "R10 busy low at done", busy, 0);
        chk(area == (AW + 1)'(e_area), "R6 area", int'(area), e_area);
        chk(best_ph == PHW'(bph), "R7 best phase", int'(best_ph), bph);
        chk(best_ofs == OFW'(bof), "R8 best offset", int'(best_ofs), bof);
        chk(no_eye == (e_area == 0), "R9 no_eye", no_eye, e_area == 0);
        break;
      end
      chk(busy == 1'b1, "R10 busy during scan", busy, 1);
      if (busy && (!pb || ofs_code != po || ph_code != pp)) begin
        if (pi >= 0) chk(sent == WIN, "R3 samples per point", sent, WIN);
        pi++;
        chk(ph_code == PHW'(pi >> OFW) && ofs_code == OFW'(pi), "R1 sweep order",
            int'({ph_code, ofs_code}), pi);
        junk = eff; sent = 0;
        if (poke && pi == 10) start = 1'b1;
      end
      if (junk > 0) begin
        smp_valid = 1'b1; smp_bit = 1'b1; junk--;
      end else if (sent < WIN) begin
        gap++;
        if (gap % 4 == 0) begin smp_valid = 1'b0; smp_bit = 1'b1; end
        else begin
          smp_valid = 1'b1; smp_bit = (sent < exp_map[pi]); sent++;
        end
      end else begin
        smp_valid = 1'b1; smp_bit = 1'b1;
      end
      pb = busy; po = ofs_code; pp = ph_code;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    chk(done == 1'b0, "R10 done single cycle", done, 0);
    for (int a = 0; a < NPT; a++) begin
      rd_addr = AW'(a);
      @(negedge clk);
      chk(rd_data == CW'(exp_map[a]), "R4 map entry", int'(rd_data), exp_map[a]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; smp_bit = 1'b0; smp_valid = 1'b0;
    settle_cycles = '0; rd_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ofs_code == 0 && ph_code == 0, "R11 reset codes", int'({ph_code, ofs_code}), 0);
    chk(busy == 0 && done == 0, "R11 reset busy/done", int'({busy, done}), 0);
    chk(area == 0 && no_eye == 0, "R11 reset results", int'(area), 0);
    chk(best_ph == 0 && best_ofs == 0, "R11 reset best", int'({best_ph, best_ofs}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    scan(0, 10, 1'b1);   // R2 plain settle, R10 start while busy, R5 boundary counts
    scan(1, 2, 1'b0);    // R2 clamp low, R9 no eye
    scan(2, 100, 1'b0);  // R2 clamp high, R7/R8 tie handling
    scan(3, 64, 1'b0);   // R6 full area, R8 whole-column run
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule